// File: doc/BRIEF.md
# Dual-Processor Mailbox Port Bank

This block passes bytes between a main CPU and an audio processor that share one clock. It holds four mailbox channels. Each channel has two registers, one for each direction. The main CPU writes a channel's inbound register and reads its outbound register, both selected by a 2-bit channel index. The audio processor reaches the same channels through its I/O window. Within that window, the offset base+N reads inbound register N and writes outbound register N.

The audio-side window also holds two auxiliary scratch bytes at offsets base+4 and base+5. The audio processor can read and write them freely. Two clear pulses come from the audio side's control register. One clears inbound channels 0 and 1, and the other clears inbound channels 2 and 3. Each read port returns its data one clock after the read strobe and holds that value until the next strobe.

Top module: `mailbox_bank`

## Requirements
- R1: After reset, every inbound, outbound and auxiliary register reads 0x00, and `host_rdata`, `aud_rdata` and `aud_hit` are 0.
- R2: A host write with `host_idx`=N stores `host_wdata` in inbound register N. A later audio read at offset BASE+N (default 0xF4+N) returns that value.
- R3: An audio write at offset BASE+N stores `aud_wdata` in outbound register N. A later host read with `host_idx`=N returns that value.
- R4: The two directions are independent. A host write never changes an outbound register, and an audio write never changes an inbound register.
- R5: While `clr_lo` is high, inbound registers 0 and 1 become 0x00 on the next clock edge. Inbound registers 2 and 3, the outbound registers and the auxiliary registers are untouched.
- R6: While `clr_hi` is high, inbound registers 2 and 3 become 0x00 on the next clock edge. Inbound registers 0 and 1, the outbound registers and the auxiliary registers are untouched.
- R7: When a host write and a clear pulse hit the same inbound register in the same cycle, the register becomes 0x00. A host write to a channel that the active clear does not cover still lands.
- R8: The offsets BASE+4 (0xF8) and BASE+5 (0xF9) are two independent read/write auxiliary bytes. The main CPU cannot reach them.
- R9: An audio access outside BASE..BASE+5 has no effect. A write there changes no register. A read there returns `aud_rdata`=0x00 with `aud_hit`=0. A read inside the window returns `aud_hit`=1.
- R10: Read data is registered. It appears on the clock edge that samples the read strobe, and it holds while no read strobe is given, even if the address or register contents change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_idx | input | 2 | Main-CPU channel index |
| host_wdata | input | DW | Main-CPU write data |
| host_wr | input | 1 | Main-CPU write strobe |
| host_rd | input | 1 | Main-CPU read strobe |
| host_rdata | output | DW | Outbound data of the indexed channel, registered |
| aud_addr | input | AW | Audio-side I/O offset |
| aud_wdata | input | DW | Audio-side write data |
| aud_wr | input | 1 | Audio-side write strobe |
| aud_rd | input | 1 | Audio-side read strobe |
| aud_rdata | output | DW | Audio-side read data, registered |
| aud_hit | output | 1 | The last audio read fell inside the window |
| clr_lo | input | 1 | Clear inbound channels 0 and 1 |
| clr_hi | input | 1 | Clear inbound channels 2 and 3 |

## Verification
The bench builds the block with its default parameters: 8-bit data, an 8-bit offset and a window base of 0xF4. With these values the all-ones, all-zeros and alternating byte patterns can be driven through every channel in both directions. The bench also probes the offsets 0xF3 and 0xFA, which sit just outside the window, and 0x00 at the far end. Clear pulses are issued alone and together with host writes, both to covered and to uncovered channels.

// File: rtl/mailbox_bank.sv
module mailbox_bank #(
  parameter int DW = 8,
  parameter int AW = 8,
  parameter logic [AW-1:0] BASE = 8'hF4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    host_idx,
  input  logic [DW-1:0] host_wdata,
  input  logic          host_wr,
  input  logic          host_rd,
  output logic [DW-1:0] host_rdata,
  input  logic [AW-1:0] aud_addr,
  input  logic [DW-1:0] aud_wdata,
  input  logic          aud_wr,
  input  logic          aud_rd,
  output logic [DW-1:0] aud_rdata,
  output logic          aud_hit,
  input  logic          clr_lo,
  input  logic          clr_hi
);
  localparam int NCH = 4;
  localparam int IW  = 2;

  logic [DW-1:0] inb  [NCH];
  logic [DW-1:0] outb [NCH];
  logic [DW-1:0] aux  [2];

  wire [AW-1:0] off     = aud_addr - BASE;
  wire          above   = aud_addr >= BASE;
  wire          mb_hit  = above && (off < AW'(NCH));
  wire          aux_hit = above && (off == AW'(NCH) || off == AW'(NCH + 1));
  wire [IW-1:0] mb_sel  = off[IW-1:0];
  wire          aux_sel = (off == AW'(NCH + 1));

  for (genvar n = 0; n < NCH; n++) begin : g_ch
    wire clr = (n < 2) ? clr_lo : clr_hi;

    always_ff @(posedge clk) begin
      if (!rst_n)                               inb[n] <= '0;
      else if (clr)                             inb[n] <= '0;
      else if (host_wr && host_idx == IW'(n))   inb[n] <= host_wdata;
    end

    always_ff @(posedge clk) begin
      if (!rst_n)                                    outb[n] <= '0;
      else if (aud_wr && mb_hit && mb_sel == IW'(n)) outb[n] <= aud_wdata;
    end
  end

  for (genvar a = 0; a < 2; a++) begin : g_aux
    always_ff @(posedge clk) begin
      if (!rst_n)                                        aux[a] <= '0;
      else if (aud_wr && aux_hit && aux_sel == (a == 1)) aux[a] <= aud_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       host_rdata <= '0;
    else if (host_rd) host_rdata <= outb[host_idx];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      aud_rdata <= '0;
      aud_hit   <= 1'b0;
    end else if (aud_rd) begin
      aud_hit   <= mb_hit || aux_hit;
      aud_rdata <= mb_hit ? inb[mb_sel] : (aux_hit ? aux[aux_sel] : '0);
    end
  end
endmodule

// File: rtl/mailbox_bank_chk.sv
module mailbox_bank_chk #(
  parameter int DW = 8,
  parameter int AW = 8,
  parameter logic [AW-1:0] BASE = 8'hF4
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    host_idx,
  input logic [DW-1:0] host_wdata,
  input logic          host_wr,
  input logic          host_rd,
  input logic [DW-1:0] host_rdata,
  input logic [AW-1:0] aud_addr,
  input logic          aud_rd,
  input logic [DW-1:0] aud_rdata,
  input logic          aud_hit,
  input logic          clr_lo,
  input logic          clr_hi,
  input logic [DW-1:0] in0,
  input logic [DW-1:0] in1,
  input logic [DW-1:0] in2,
  input logic [DW-1:0] in3
);
  wire covered  = host_idx[1] ? clr_hi : clr_lo;
  wire outside  = (aud_addr < BASE) || (aud_addr > BASE + AW'(5));
  wire [DW-1:0] sel_in = host_idx == 2'd0 ? in0 : host_idx == 2'd1 ? in1 :
                         host_idx == 2'd2 ? in2 : in3;

  // R5
  clr_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_lo |=> (in0 == '0 && in1 == '0));

  // R6
  clr_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_hi |=> (in2 == '0 && in3 == '0));

  // R2
  host_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && !covered) |=> ($past(host_wdata) ==
      ($past(host_idx) == 2'd0 ? in0 : $past(host_idx) == 2'd1 ? in1 :
       $past(host_idx) == 2'd2 ? in2 : in3)));

  // R7
  clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && covered) |=> ($past(host_idx) == 2'd0 ? in0 : $past(host_idx) == 2'd1 ? in1 :
       $past(host_idx) == 2'd2 ? in2 : in3) == '0);

  // R4
  inb_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!host_wr && !clr_lo && !clr_hi) |=>
      ($stable(in0) && $stable(in1) && $stable(in2) && $stable(in3)));

  // R9
  outside_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (aud_rd && outside) |=> (aud_rdata == '0 && !aud_hit));

  // R10
  host_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !host_rd |=> $stable(host_rdata));

  // R10
  aud_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !aud_rd |=> ($stable(aud_rdata) && $stable(aud_hit)));

  wire unused_ok = ^sel_in;
endmodule

bind mailbox_bank mailbox_bank_chk #(.DW(DW), .AW(AW), .BASE(BASE)) u_chk (
  .clk(clk), .rst_n(rst_n), .host_idx(host_idx), .host_wdata(host_wdata),
  .host_wr(host_wr), .host_rd(host_rd), .host_rdata(host_rdata),
  .aud_addr(aud_addr), .aud_rd(aud_rd), .aud_rdata(aud_rdata), .aud_hit(aud_hit),
  .clr_lo(clr_lo), .clr_hi(clr_hi),
  .in0(inb[0]), .in1(inb[1]), .in2(inb[2]), .in3(inb[3])
);

// File: tb/tb_mailbox_bank.sv
module tb_mailbox_bank;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] host_idx;
  logic [7:0] host_wdata, host_rdata;
  logic       host_wr, host_rd;
  logic [7:0] aud_addr, aud_wdata, aud_rdata;
  logic       aud_wr, aud_rd, aud_hit;
  logic       clr_lo, clr_hi;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  mailbox_bank dut (
    .clk(clk), .rst_n(rst_n),
    .host_idx(host_idx), .host_wdata(host_wdata), .host_wr(host_wr),
    .host_rd(host_rd), .host_rdata(host_rdata),
    .aud_addr(aud_addr), .aud_wdata(aud_wdata), .aud_wr(aud_wr),
    .aud_rd(aud_rd), .aud_rdata(aud_rdata), .aud_hit(aud_hit),
    .clr_lo(clr_lo), .clr_hi(clr_hi)
  );

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic host_write(input logic [1:0] i, input logic [7:0] d);
    @(negedge clk); host_idx = i; host_wdata = d; host_wr = 1'b1;
    @(negedge clk); host_wr = 1'b0;
  endtask

  task automatic host_read(input logic [1:0] i, output logic [7:0] d);
    @(negedge clk); host_idx = i; host_rd = 1'b1;
    @(negedge clk); host_rd = 1'b0; d = host_rdata;
  endtask

  task automatic aud_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); aud_addr = a; aud_wdata = d; aud_wr = 1'b1;
    @(negedge clk); aud_wr = 1'b0;
  endtask

  task automatic aud_read(input logic [7:0] a, output logic [7:0] d, output logic h);
    @(negedge clk); aud_addr = a; aud_rd = 1'b1;
    @(negedge clk); aud_rd = 1'b0; d = aud_rdata; h = aud_hit;
  endtask

  task automatic t_reset;
    logic [7:0] d; logic h;
    check("R1 host_rdata", host_rdata, 0);
    check("R1 aud_rdata", aud_rdata, 0);
    check("R1 aud_hit", aud_hit, 0);
    for (int n = 0; n < 4; n++) begin
      host_read(2'(n), d); check("R1 outbound", d, 0);
    end
    for (int a = 8'hF4; a <= 8'hF9; a++) begin
      aud_read(8'(a), d, h); check("R1 window reg", d, 0);
    end
  endtask

  task automatic t_host_to_aud;
    logic [7:0] d; logic h;
    logic [7:0] pat [4] = '{8'hA5, 8'h5A, 8'hFF, 8'h01};
    for (int n = 0; n < 4; n++) host_write(2'(n), pat[n]);
    for (int n = 0; n < 4; n++) begin
      aud_read(8'(8'hF4 + n), d, h);
      check("R2 inbound data", d, pat[n]);
      check("R9 hit in window", h, 1);
    end
  endtask

  task automatic t_aud_to_host;
    logic [7:0] d; logic h;
    logic [7:0] pat [4] = '{8'h11, 8'h80, 8'h3C, 8'hC3};
    for (int n = 0; n < 4; n++) aud_write(8'(8'hF4 + n), pat[n]);
    for (int n = 0; n < 4; n++) begin
      host_read(2'(n), d); check("R3 outbound data", d, pat[n]);
    end
    aud_read(8'hF5, d, h); check("R4 inbound untouched by audio write", d, 8'h5A);
    host_write(2'd2, 8'h99);
    host_read(2'd2, d); check("R4 outbound untouched by host write", d, 8'h3C);
  endtask

  task automatic t_clr_lo;
    logic [7:0] d; logic h;
    for (int n = 0; n < 4; n++) host_write(2'(n), 8'(8'h40 + n));
    @(negedge clk); clr_lo = 1'b1;
    @(negedge clk); clr_lo = 1'b0;
    aud_read(8'hF4, d, h); check("R5 ch0 cleared", d, 0);
    aud_read(8'hF5, d, h); check("R5 ch1 cleared", d, 0);
    aud_read(8'hF6, d, h); check("R5 ch2 kept", d, 8'h42);
    aud_read(8'hF7, d, h); check("R5 ch3 kept", d, 8'h43);
    host_read(2'd0, d); check("R5 outbound kept", d, 8'h11);
  endtask

  task automatic t_clr_hi;
    logic [7:0] d; logic h;
    for (int n = 0; n < 4; n++) host_write(2'(n), 8'(8'h60 + n));
    @(negedge clk); clr_hi = 1'b1;
    @(negedge clk); clr_hi = 1'b0;
    aud_read(8'hF4, d, h); check("R6 ch0 kept", d, 8'h60);
    aud_read(8'hF5, d, h); check("R6 ch1 kept", d, 8'h61);
    aud_read(8'hF6, d, h); check("R6 ch2 cleared", d, 0);
    aud_read(8'hF7, d, h); check("R6 ch3 cleared", d, 0);
    host_read(2'd3, d); check("R6 outbound kept", d, 8'hC3);
  endtask

  task automatic t_collision;
    logic [7:0] d; logic h;
    @(negedge clk); host_idx = 2'd1; host_wdata = 8'h77; host_wr = 1'b1; clr_lo = 1'b1;
    @(negedge clk); host_wr = 1'b0; clr_lo = 1'b0;
    aud_read(8'hF5, d, h); check("R7 clear beats write", d, 0);
    @(negedge clk); host_idx = 2'd2; host_wdata = 8'h5E; host_wr = 1'b1; clr_lo = 1'b1;
    @(negedge clk); host_wr = 1'b0; clr_lo = 1'b0;
    aud_read(8'hF6, d, h); check("R7 uncovered write lands", d, 8'h5E);
    @(negedge clk); host_idx = 2'd3; host_wdata = 8'hE1; host_wr = 1'b1; clr_hi = 1'b1;
    @(negedge clk); host_wr = 1'b0; clr_hi = 1'b0;
    aud_read(8'hF7, d, h); check("R7 clear_hi beats write", d, 0);
  endtask

  task automatic t_aux;
    logic [7:0] d; logic h;
    aud_write(8'hF8, 8'hDE);
    aud_write(8'hF9, 8'hAD);
    aud_read(8'hF8, d, h); check("R8 aux0", d, 8'hDE); check("R8 aux hit", h, 1);
    aud_read(8'hF9, d, h); check("R8 aux1", d, 8'hAD);
    host_write(2'd0, 8'h12);
    aud_read(8'hF8, d, h); check("R8 aux0 not host reachable", d, 8'hDE);
  endtask

  task automatic t_outside;
    logic [7:0] d; logic h;
    aud_write(8'hF3, 8'hFF);
    aud_write(8'hFA, 8'hFF);
    aud_write(8'h00, 8'hFF);
    aud_read(8'hF3, d, h); check("R9 below read data", d, 0); check("R9 below hit", h, 0);
    aud_read(8'hFA, d, h); check("R9 above read data", d, 0); check("R9 above hit", h, 0);
    aud_read(8'hF9, d, h); check("R9 aux1 untouched", d, 8'hAD);
    host_read(2'd0, d); check("R9 outbound0 untouched", d, 8'h11);
    host_read(2'd3, d); check("R9 outbound3 untouched", d, 8'hC3);
  endtask

  task automatic t_hold;
    logic [7:0] d; logic h;
    host_read(2'd1, d); check("R10 host read", d, 8'h80);
    aud_write(8'hF5, 8'h2B);
    @(negedge clk); host_idx = 2'd2;
    @(negedge clk); check("R10 host_rdata holds", host_rdata, 8'h80);
    aud_read(8'hF8, d, h);
    @(negedge clk); aud_addr = 8'hF3;
    @(negedge clk); check("R10 aud_rdata holds", aud_rdata, 8'hDE);
    check("R10 aud_hit holds", aud_hit, 1);
    host_read(2'd1, d); check("R10 new read sees update", d, 8'h2B);
  endtask

  initial begin
    rst_n = 1'b0; host_idx = '0; host_wdata = '0; host_wr = 0; host_rd = 0;
    aud_addr = '0; aud_wdata = '0; aud_wr = 0; aud_rd = 0; clr_lo = 0; clr_hi = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_host_to_aud();
    t_aud_to_host();
    t_clr_lo();
    t_clr_hi();
    t_collision();
    t_aux();
    t_outside();
    t_hold();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      done = 1'b1;
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule